// File: doc/BRIEF.md
# Two-Wire Serial Byte Memory Slave

This block models the slave end of a tiny serial data memory on a two-wire bus. The bus has one serial clock line and one open-drain data line. The block holds sixteen bytes in registers. It samples both bus lines on the system clock and finds the bus conditions from the sampled edges. A high-to-low data edge while the clock is high begins a transfer. A low-to-high data edge while the clock is high ends one. Between those two conditions it takes in a control byte, answers with an acknowledge, and then either stores bytes or sends them out.

Three operations are supported. A byte write sends the control byte, an address and one data byte. A current-address read returns the byte at the pointer the block already holds, since the pointer is kept from one transaction to the next. A random read loads the pointer with a dummy write, then uses a repeated begin condition and a read control byte. After a write is closed by an end condition, an internal programming timer runs, and the block stays off the bus until the timer expires.

Top module: `eeprom2w_slave`

## Requirements
- R1: The store holds 16 bytes. Only the low 4 bits of a received address byte select a location, so address 0x13 reaches location 3.
- R2: Out of reset, and whenever no transfer is active, the block releases the data line (sda_pull = 0). A falling data edge while the clock is high is a begin condition. A rising data edge while the clock is high is an end condition.
- R3: The control byte is accepted when its upper nibble is 1010. Its lowest bit selects the direction: 0 is write, 1 is read. Bits 3..1 are ignored. A control byte that does not match gets no acknowledge, and every later byte is ignored until the next begin condition.
- R4: After each byte it accepts, the block holds the data line low for the whole high period of the ninth clock.
- R5: A byte write (write control byte, address byte, data byte, end condition) stores the data byte at the given address.
- R6: The pointer advances by one after each byte that is written or read, and it wraps from 15 to 0.
- R7: A read control byte that follows a begin condition returns the byte at the pointer held from earlier transactions.
- R8: A write control byte and an address byte, followed by a repeated begin condition and a read control byte, return the byte at that address.
- R9: When the master does not acknowledge a byte that was read, the block stops sending and leaves the data line released.
- R10: The block changes its data drive only after a falling clock edge. Bits are taken while the clock is high.
- R11: An end condition that follows at least one stored data byte starts a programming timer of PROG_CYCLES clocks. While the timer runs, control bytes get no acknowledge. After it expires, they are acknowledged again.
- R12: An end condition that follows no stored data byte (for example after a random read) does not start the programming timer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_in | input | 1 | Serial clock line as seen at the block |
| sda_in | input | 1 | Serial data line as seen at the block (wired value) |
| sda_pull | output | 1 | 1 pulls the data line low; 0 releases it |

## Verification
Inline properties watch the per-cycle rules on every clock. The data drive may change only after a sampled falling clock edge. The line stays released whenever the block is idle or the programming timer runs. The timer may only start from an end condition. The drive holds steady through each acknowledge high phase. The stored contents, the pointer that persists and wraps, the random read set up by a dummy write, the control-byte match and the recovery once the timer ends all depend on what came before. Only the bench scenarios can show these, by reading back what earlier transfers left behind.

// File: rtl/eeprom2w_slave.sv
module eeprom2w_slave #(
  parameter int          ADDR_W      = 4,
  parameter int          PROG_CYCLES = 500,
  parameter logic [3:0]  DEV_ID      = 4'b1010
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_pull
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int BW    = $clog2(PROG_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_CTRL, S_ADDR, S_WDAT, S_RDAT} st_t;

  st_t               st;
  logic              scl_q, sda_q, ackph, wrote, mack;
  logic [3:0]        cnt;
  logic [7:0]        sh, tx;
  logic [ADDR_W-1:0] ptr;
  logic [BW-1:0]     busy;
  logic [7:0]        mem [DEPTH];

  wire start_c = scl_q & scl_in & sda_q & ~sda_in;
  wire stop_c  = scl_q & scl_in & ~sda_q & sda_in;
  wire rise    = ~scl_q & scl_in;
  wire fall    = scl_q & ~scl_in;
  wire ctrl_ok = (sh[7:4] == DEV_ID);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; scl_q <= 1'b1; sda_q <= 1'b1; ackph <= 1'b0;
      wrote <= 1'b0; mack <= 1'b0; cnt <= '0; sh <= '0; tx <= '0;
      ptr <= '0; busy <= '0; sda_pull <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      scl_q <= scl_in;
      sda_q <= sda_in;
      if (busy != '0) busy <= busy - BW'(1);
      if (stop_c) begin
        st <= S_IDLE; sda_pull <= 1'b0; ackph <= 1'b0;
        if (wrote) begin
          busy  <= BW'(PROG_CYCLES);
          wrote <= 1'b0;
        end
      end else if (start_c) begin
        sda_pull <= 1'b0; ackph <= 1'b0; cnt <= '0;
        st <= (busy == '0) ? S_CTRL : S_IDLE;
      end else if (st == S_RDAT) begin
        if (rise) begin
          if (ackph) mack <= ~sda_in;
          else       cnt  <= cnt + 4'd1;
        end
        if (fall) begin
          if (ackph) begin
            ackph <= 1'b0;
            if (mack) begin
              tx <= mem[ptr]; sda_pull <= ~mem[ptr][7]; cnt <= '0;
            end else begin
              st <= S_IDLE;
            end
          end else if (cnt == 4'd8) begin
            sda_pull <= 1'b0; ackph <= 1'b1; ptr <= ptr + 1'b1;
          end else begin
            tx <= {tx[6:0], 1'b0}; sda_pull <= ~tx[6];
          end
        end
      end else if (st != S_IDLE) begin
        if (rise && !ackph) begin
          sh  <= {sh[6:0], sda_in};
          cnt <= cnt + 4'd1;
        end
        if (fall) begin
          if (ackph) begin
            ackph <= 1'b0; cnt <= '0; sda_pull <= 1'b0;
          end else if (cnt == 4'd8) begin
            ackph <= 1'b1;
            case (st)
              S_CTRL: if (ctrl_ok) begin
                sda_pull <= 1'b1;
                if (sh[0]) begin st <= S_RDAT; mack <= 1'b1; end
                else st <= S_ADDR;
              end else st <= S_IDLE;
              S_ADDR: begin ptr <= sh[ADDR_W-1:0]; sda_pull <= 1'b1; st <= S_WDAT; end
              S_WDAT: begin mem[ptr] <= sh; ptr <= ptr + 1'b1; wrote <= 1'b1; sda_pull <= 1'b1; end
              default: st <= S_IDLE;
            endcase
          end
        end
      end
    end
  end

  assert_drive_on_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull != $past(sda_pull)) |-> !scl_q);
  assert_idle_released_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sda_pull);
  assert_quiet_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy != '0) |-> !sda_pull);
  assert_timer_from_stop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy != '0) |-> $past(stop_c));
  assert_ack_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ackph && st != S_RDAT && st != S_IDLE && scl_q && scl_in) |-> $stable(sda_pull));
endmodule

// File: tb/eeprom2w_slave_test.sv
module eeprom2w_slave_test;
  localparam int CLK_P = 10;
  localparam int HALF  = 4;
  localparam int PROG  = 500;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
  logic pull;
  wire  sda_bus = sda_m & ~pull;
  int   total = 0, bad = 0;
  bit   done = 1'b0;

  logic [7:0] exp_v[$];
  string      exp_t[$];
  logic [7:0] got;
  event       got_ev;

  always #(CLK_P/2) clk = ~clk;

  eeprom2w_slave #(.PROG_CYCLES(PROG)) uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_bus), .sda_pull(pull));

  initial forever begin
    logic [7:0] e; string t;
    @(got_ev);
    e = exp_v.pop_front(); t = exp_t.pop_front();
    total++;
    if (got !== e) begin
      bad++;
      $display("FAIL %s: got %h expected %h", t, got, e);
    end
  end

  task automatic expect_item(input logic [7:0] v, input string t);
    exp_v.push_back(v); exp_t.push_back(t);
  endtask
  task automatic report(input logic [7:0] v);
    got = v; -> got_ev;
  endtask
  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_cyc(HALF); scl = 1'b1; wait_cyc(HALF);
    sda_m = 1'b0; wait_cyc(HALF); scl = 1'b0; wait_cyc(HALF);
  endtask
  task automatic bus_stop();
    sda_m = 1'b0; wait_cyc(HALF); scl = 1'b1; wait_cyc(HALF);
    sda_m = 1'b1; wait_cyc(HALF);
  endtask
  task automatic clock_bit(input logic b, output logic s);
    sda_m = b; wait_cyc(HALF); scl = 1'b1; wait_cyc(HALF/2);
    s = sda_bus; wait_cyc(HALF/2); scl = 1'b0;
  endtask
  task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string t);
    logic s;
    expect_item({7'd0, exp_ack}, t);
    for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
    clock_bit(1'b1, s);
    report({7'd0, ~s});
  endtask
  task automatic recv_byte(input logic [7:0] e, input logic ack, input string t);
    logic s; logic [7:0] r;
    expect_item(e, t);
    for (int i = 7; i >= 0; i--) begin clock_bit(1'b1, s); r[i] = s; end
    report(r);
    clock_bit(~ack, s);
  endtask
  task automatic write_byte(input logic [7:0] a, input logic [7:0] d);
    bus_start();
    send_byte(8'hA0, 1'b1, "R3 write control ack");
    send_byte(a, 1'b1, "R4 address ack");
    send_byte(d, 1'b1, "R5 data ack");
    bus_stop();
  endtask

  initial begin
    wait_cyc(10); rst_n = 1'b1; wait_cyc(4);
    expect_item(8'd1, "R2 line released after reset"); report({7'd0, sda_bus});

    write_byte(8'h13, 8'hA5);
    bus_start(); send_byte(8'hA0, 1'b0, "R11 no ack while programming"); bus_stop();
    wait_cyc(PROG + 20);
    bus_start(); send_byte(8'hAE, 1'b1, "R11 R3 ack after timer, ignored bits"); bus_stop();

    write_byte(8'h00, 8'h5A); wait_cyc(PROG + 20);
    write_byte(8'h0F, 8'h3C); wait_cyc(PROG + 20);

    bus_start();
    send_byte(8'hA1, 1'b1, "R7 read control ack");
    recv_byte(8'h5A, 1'b1, "R7 R6 R10 current read after wrap");
    recv_byte(8'h00, 1'b0, "R6 next location");
    wait_cyc(2);
    expect_item(8'd1, "R9 released after master no-ack"); report({7'd0, sda_bus});
    bus_stop();

    bus_start();
    send_byte(8'hA0, 1'b1, "R8 dummy write control");
    send_byte(8'h03, 1'b1, "R8 address");
    bus_start();
    send_byte(8'hA1, 1'b1, "R8 read control");
    recv_byte(8'hA5, 1'b0, "R8 R1 random read of folded address");
    bus_stop();
    bus_start(); send_byte(8'hA0, 1'b1, "R12 no timer after read"); bus_stop();

    bus_start();
    send_byte(8'h51, 1'b0, "R3 mismatched control");
    send_byte(8'hA0, 1'b0, "R3 ignored until next begin");
    bus_stop();

    bus_start();
    send_byte(8'hA0, 1'b1, "R6 dummy write");
    send_byte(8'h0F, 1'b1, "R6 address 15");
    bus_start();
    send_byte(8'hA1, 1'b1, "R6 read control");
    recv_byte(8'h3C, 1'b1, "R6 R10 location 15");
    recv_byte(8'h5A, 1'b0, "R6 wrapped to location 0");
    bus_stop();

    wait_cyc(10);
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule